// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display. It also presents the live pixel coordinates so that downstream fetch logic can line its reads up with the active window. The whole timing is set through a narrow write-only register port: a frame extent, two sync windows with their own polarity bits, and the two corners of the visible region.

A horizontal counter runs across each line, and a vertical counter steps once per line. Each sync pulse is described by the counter value that switches it on and the value that switches it off. Because of this, a horizontal pulse may straddle the end of the line and continue into the start of the next one. The vertical blanking order is front porch, then sync, then back porch, so the visible lines sit at the end of the frame.

Register writes go into a staging copy. The live copy is refreshed only on the last pixel of the last line, or at any time while the generator is stopped. A mode change therefore never tears a frame.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the generator is stopped and pix_x and pix_y are 0. Every polarity bit resets to 0, so hsync, vsync and de all sit at their inactive level, which is 1.
- R2: The register at 0x10 holds the frame extent: the last x count in bits [15:0] and the last y count in bits [31:16]. While running, pix_x counts up by one per clock from 0 to the last x count, then returns to 0.
- R3: pix_y holds its value during a line and advances by one on the clock after pix_x equals the last x count. After the last y count it returns to 0.
- R4: The register at 0x20 sets horizontal sync: bit 31 = polarity (1 = active high), bits [30:16] = stop count, bits [15:0] = start count. Sync turns active on the clock after pix_x equals the start count and inactive on the clock after it equals the stop count, so the pulse may wrap through x = 0.
- R5: The register at 0x30 sets vertical sync with the same field layout. Its start and stop counts are compared with pix_y on the last pixel of a line, so the pulse begins and ends together with the first pixel of a line.
- R6: The register at 0x40 holds the visible region's first corner: x in bits [15:0], y in bits [30:16] and the de polarity in bit 31. The register at 0x50 holds the last corner: x in bits [15:0] and y in bits [31:16]. de is active in the same cycle as a coordinate with corner1_x < pix_x <= corner2_x and corner1_y <= pix_y <= corner2_y.
- R7: A polarity bit of 0 inverts its output, so the active level becomes 0 and the inactive level becomes 1.
- R8: A write made while running takes no effect until the clock after pix_x and pix_y both equal their last counts.
- R9: Bit 0 of the register at 0x00 starts the generator. Writing 0 to it returns both counters to 0 on the next clock and holds every output at its inactive level while stopped.
- R10: Writes to addresses other than 0x00, 0x10, 0x20, 0x30, 0x40 and 0x50 (for example 0x14 or 0x60) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity as programmed |
| vsync | output | 1 | Vertical sync, polarity as programmed |
| de | output | 1 | Data enable, polarity as programmed |
| pix_x | output | CNT_W | Current horizontal count |
| pix_y | output | CNT_W | Current vertical count |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a frame. The staging copy must stay hidden until exactly the frame boundary and then take over on the very next pixel. The stimulus tracks the absolute pixel index from the moment the generator starts. It writes a polarity change to horizontal sync part way through one frame. It then samples hsync later in the same frame, where the old polarity must still hold, and again in the following frame, both inside and outside the pulse, where the new polarity must show.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   localparam int FLD_W = 16;

   localparam logic [7:0] OFS_CTRL  = 8'h00;
   localparam logic [7:0] OFS_EXT   = 8'h10;
   localparam logic [7:0] OFS_HWIN  = 8'h20;
   localparam logic [7:0] OFS_VWIN  = 8'h30;
   localparam logic [7:0] OFS_VIS_A = 8'h40;
   localparam logic [7:0] OFS_VIS_B = 8'h50;

   typedef struct packed {
      logic [FLD_W-1:0] last_x;
      logic [FLD_W-1:0] last_y;
      logic [FLD_W-1:0] hs_on;
      logic [FLD_W-1:0] hs_off;
      logic             hs_pol;
      logic [FLD_W-1:0] vs_on;
      logic [FLD_W-1:0] vs_off;
      logic             vs_pol;
      logic [FLD_W-1:0] vis_x0;
      logic [FLD_W-1:0] vis_y0;
      logic [FLD_W-1:0] vis_x1;
      logic [FLD_W-1:0] vis_y1;
      logic             de_pol;
   } dtg_cfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              frame_done,
   output logic              run,
   output dtg_cfg_t          cfg_live
);
   dtg_cfg_t stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= '0;
         run   <= 1'b0;
      end else if (we) begin
         if (addr == ADDR_W'(OFS_CTRL)) begin
            run <= wdata[0];
         end else if (addr == ADDR_W'(OFS_EXT)) begin
            stage.last_x <= wdata[15:0];
            stage.last_y <= wdata[31:16];
         end else if (addr == ADDR_W'(OFS_HWIN)) begin
            stage.hs_pol <= wdata[31];
            stage.hs_off <= {1'b0, wdata[30:16]};
            stage.hs_on  <= wdata[15:0];
         end else if (addr == ADDR_W'(OFS_VWIN)) begin
            stage.vs_pol <= wdata[31];
            stage.vs_off <= {1'b0, wdata[30:16]};
            stage.vs_on  <= wdata[15:0];
         end else if (addr == ADDR_W'(OFS_VIS_A)) begin
            stage.de_pol <= wdata[31];
            stage.vis_y0 <= {1'b0, wdata[30:16]};
            stage.vis_x0 <= wdata[15:0];
         end else if (addr == ADDR_W'(OFS_VIS_B)) begin
            stage.vis_y1 <= wdata[31:16];
            stage.vis_x1 <= wdata[15:0];
         end
      end
   end

   // live copy follows the staging copy while stopped or at the frame seam
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cfg_live <= '0;
      else if (!run || frame_done) cfg_live <= stage;
   end
endmodule

// File: rtl/dtg_scan.sv
module dtg_scan
   import dtg_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [FLD_W-1:0] last_x,
   input  logic [FLD_W-1:0] last_y,
   output logic [CNT_W-1:0] h_cnt,
   output logic [CNT_W-1:0] v_cnt,
   output logic             line_done,
   output logic             frame_done
);
   localparam int PAD_W = FLD_W - CNT_W;

   logic [FLD_W-1:0] h_wide, v_wide;
   assign h_wide     = {{PAD_W{1'b0}}, h_cnt};
   assign v_wide     = {{PAD_W{1'b0}}, v_cnt};
   assign line_done  = run && (h_wide == last_x);
   assign frame_done = line_done && (v_wide == last_y);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (!run) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (line_done) begin
         h_cnt <= '0;
         v_cnt <= frame_done ? '0 : v_cnt + 1'b1;
      end else begin
         h_cnt <= h_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dtg_pulse.sv
module dtg_pulse
   import dtg_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt,
   input  logic [FLD_W-1:0] on_at,
   input  logic [FLD_W-1:0] off_at,
   input  logic             pol,
   output logic             pin
);
   localparam int PAD_W = FLD_W - CNT_W;

   logic             active;
   logic [FLD_W-1:0] cnt_wide;
   assign cnt_wide = {{PAD_W{1'b0}}, cnt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     active <= 1'b0;
      else if (!run)                  active <= 1'b0;
      else if (step) begin
         if (cnt_wide == on_at)       active <= 1'b1;
         else if (cnt_wide == off_at) active <= 1'b0;
      end
   end

   assign pin = active ^ ~pol;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import dtg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [CNT_W-1:0]  pix_x,
   output logic [CNT_W-1:0]  pix_y
);
   localparam int PAD_W = FLD_W - CNT_W;
   localparam int N_SYNC = 2;

   generate
      if (CNT_W < 2 || CNT_W > FLD_W - 1) begin : g_bad_cnt
         $error("CNT_W must lie in 2..15");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W must be at least 7");
      end
   endgenerate

   logic     run, line_done, frame_done;
   dtg_cfg_t cfg_live;

   dtg_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .frame_done(frame_done), .run(run),
      .cfg_live(cfg_live)
   );

   dtg_scan #(.CNT_W(CNT_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .run(run),
      .last_x(cfg_live.last_x), .last_y(cfg_live.last_y),
      .h_cnt(pix_x), .v_cnt(pix_y),
      .line_done(line_done), .frame_done(frame_done)
   );

   logic [N_SYNC-1:0] sync_pin;

   generate
      for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
         if (i == 0) begin : g_h
            dtg_pulse #(.CNT_W(CNT_W)) u_pulse (
               .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1),
               .cnt(pix_x), .on_at(cfg_live.hs_on), .off_at(cfg_live.hs_off),
               .pol(cfg_live.hs_pol), .pin(sync_pin[i])
            );
         end else begin : g_v
            dtg_pulse #(.CNT_W(CNT_W)) u_pulse (
               .clk(clk), .rst_n(rst_n), .run(run), .step(line_done),
               .cnt(pix_y), .on_at(cfg_live.vs_on), .off_at(cfg_live.vs_off),
               .pol(cfg_live.vs_pol), .pin(sync_pin[i])
            );
         end
      end
   endgenerate

   assign hsync = sync_pin[0];
   assign vsync = sync_pin[1];

   logic [FLD_W-1:0] x_wide, y_wide;
   logic             in_vis;
   assign x_wide = {{PAD_W{1'b0}}, pix_x};
   assign y_wide = {{PAD_W{1'b0}}, pix_y};

   always_comb begin
      in_vis = run
            && (x_wide >  cfg_live.vis_x0) && (x_wide <= cfg_live.vis_x1)
            && (y_wide >= cfg_live.vis_y0) && (y_wide <= cfg_live.vis_y1);
   end

   assign de = in_vis ^ ~cfg_live.de_pol;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
   import dtg_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [CNT_W-1:0] pix_x,
   input logic [CNT_W-1:0] pix_y,
   input dtg_cfg_t         cfg
);
   localparam int PAD_W = FLD_W - CNT_W;

   logic [FLD_W-1:0] xw, yw;
   logic             at_eol, at_eof;
   assign xw     = {{PAD_W{1'b0}}, pix_x};
   assign yw     = {{PAD_W{1'b0}}, pix_y};
   assign at_eol = run && (xw == cfg.last_x);
   assign at_eof = at_eol && (yw == cfg.last_y);

   // R2
   x_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_eol |=> pix_x == '0);

   // R2
   x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_eol) |=> pix_x == CNT_W'($past(pix_x) + 1'b1));

   // R3
   y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_eol) |=> $stable(pix_y));

   // R3
   y_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_eof |=> pix_y == '0);

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_eof) |=> $stable(cfg));

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pix_x == '0 && pix_y == '0));
endmodule

bind disp_timing_gen dtg_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run),
   .pix_x(pix_x), .pix_y(pix_y), .cfg(cfg_live)
);

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;
   localparam int ADDR_W = 8;
   localparam int CNT_W  = 12;
   localparam int FRAME  = 17 * 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [31:0]       cfg_wdata = '0;
   logic              hsync, vsync, de;
   logic [CNT_W-1:0]  pix_x, pix_y;

   int  n_chk = 0, n_bad = 0, cur = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   disp_timing_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
      .pix_x(pix_x), .pix_y(pix_y)
   );

   // {x, y, hsync, vsync, de} sampled in the second frame, all polarities high
   localparam logic [14:0] VEC [16] = '{
      {8'd0,  4'd0, 3'b100}, {8'd2,  4'd0, 3'b100}, {8'd3,  4'd0, 3'b000},
      {8'd16, 4'd0, 3'b000}, {8'd0,  4'd1, 3'b110}, {8'd5,  4'd1, 3'b010},
      {8'd16, 4'd2, 3'b010}, {8'd0,  4'd3, 3'b100}, {8'd10, 4'd4, 3'b000},
      {8'd6,  4'd5, 3'b000}, {8'd7,  4'd5, 3'b001}, {8'd14, 4'd5, 3'b001},
      {8'd15, 4'd5, 3'b000}, {8'd7,  4'd8, 3'b001}, {8'd14, 4'd8, 3'b001},
      {8'd16, 4'd8, 3'b000}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (pixel index %0d)", req, act, exp, cur);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      cur++;
   endtask

   task automatic go_to(input int k);
      while (cur < k) begin
         @(posedge clk);
         cur++;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 hsync", hsync, 1); check("R1 vsync", vsync, 1);
      check("R1 de", de, 1);
      check("R1 pix_x", pix_x, 0); check("R1 pix_y", pix_y, 0);

      // total 17 x 9: xres 8, left 4, hsync 3, right 2; yres 4, upper 2, lower 1, vsync 2
      wr(8'h10, 32'h0008_0010);
      wr(8'h20, 32'h8002_0010);
      wr(8'h30, 32'h8002_0000);
      wr(8'h40, 32'h8005_0006);
      wr(8'h50, 32'h0008_000E);
      wr(8'h00, 32'h0000_0001);
      cur = 0;

      foreach (VEC[i]) begin
         automatic int vx = int'(VEC[i][14:7]);
         automatic int vy = int'(VEC[i][6:3]);
         go_to(FRAME + vy * 17 + vx);
         check("R2 pix_x", pix_x, vx);
         check("R3 pix_y", pix_y, vy);
         check("R4 hsync", hsync, VEC[i][2]);
         check("R5 vsync", vsync, VEC[i][1]);
         check("R6 de", de, VEC[i][0]);
      end

      // R8 / R7: flip hsync polarity mid-frame
      go_to(2 * FRAME + 20);
      wr(8'h20, 32'h0002_0010);
      go_to(2 * FRAME + 35);
      check("R8 hsync old polarity kept", hsync, 1);
      go_to(3 * FRAME + 18);
      check("R7 hsync active low", hsync, 0);
      go_to(3 * FRAME + 22);
      check("R7 hsync idle high", hsync, 1);

      // R10: undecoded offsets
      wr(8'h60, 32'h0000_0000);
      wr(8'h14, 32'h0000_0000);
      go_to(4 * FRAME + 16);
      check("R10 pix_x", pix_x, 16);
      check("R10 pix_y", pix_y, 0);
      go_to(4 * FRAME + 5 * 17 + 7);
      check("R10 de", de, 1);

      // R9: stop
      wr(8'h00, 32'h0000_0000);
      @(posedge clk); @(negedge clk);
      check("R9 pix_x", pix_x, 0); check("R9 pix_y", pix_y, 0);
      check("R9 hsync", hsync, 1); check("R9 vsync", vsync, 0);
      check("R9 de", de, 0);
      repeat (5) @(negedge clk);
      check("R9 pix_x held", pix_x, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end
endmodule